// File: doc/BRIEF.md
# Chained Serial-to-Parallel Output Receiver

This block takes asynchronous serial characters from a single line and pushes each data bit, as soon as it is sampled, into a cascade of 8-bit output stages. The stages drive parallel output channels: four stages, or 32 channels, by default. There is no character buffer and no valid strobe. A falling start edge starts a bit-period timer. The timer samples the line in the middle of each of the eight data bits. After the eighth sample the timer stops and the block waits again.

The outputs carry the inverse of the shifted bits, so reset leaves every channel high. After the last sample of a character, a dead window of `HOLD_BITS` bit periods masks any new start edge. A sender must therefore leave two stop bits between characters. The bit period is a parameter counted in system clocks. At 50 MHz, 5208 clocks gives 9600 baud and 868 clocks gives 57600 baud, both well inside a 5% timing error. A chain is written by sending one character per stage. The character sent last ends up in stage 0.

Top module: `serial_chain_rx`

## Requirements
- R1: A synchronous reset, active high on `rst`, drives every bit of `chan_out` to 1 and leaves the block waiting for a start edge.
- R2: The line idles at 1. A frame is one start bit at 0, then 8 data bits sent least-significant bit first, then stop time at 1. The first data bit is sampled about 1.5 bit periods after the start edge and each later bit one bit period after the previous one. The start bit is never shifted in.
- R3: Outputs are inverted. Receiving 0xFF drives stage 0 (`chan_out[7:0]`) to all 0, and receiving 0x00 drives it to all 1. Bit i of a character received last appears inverted on `chan_out[i]`.
- R4: Stage k occupies `chan_out[8k+7:8k]`, and stage 0 holds the newest character. On each sample, every stage shifts toward its bit 0, stage 0 takes the new bit at its bit 7, and stage k+1 bit 7 takes the old stage k bit 0. The bit that leaves the last stage is lost.
- R5: The outputs change at every sampled bit while a character is arriving. After 4 of the 8 data bits have been sampled, the chain has shifted exactly four positions.
- R6: After the eighth sample the sample count clears and the block returns to waiting. The outputs hold while it waits. A next frame sent after two stop bits is received in full.
- R7: A falling edge that arrives within `HOLD_BITS` bit periods after the eighth sample is ignored. A 0xFF frame sent after only one stop bit leaves `chan_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| chan_out | output | 8*STAGES | Inverted parallel channels; stage 0 in the low byte |

## Verification
The characters 0x41, 0xFF, 0x00, 0xA5, 0x3C and 0x5A are sent in turn. 0x41 shows the bit order and rules out a shifted-in start bit. 0xFF and 0x00 show the output inversion at its extremes. A run of five or more characters pushes data off the far end and shows the stage-to-stage carry. A check in the middle of a frame separates a directly shifting chain from one that updates on whole characters. A 0xFF frame sent after a single stop bit, followed by a normally spaced frame, shows that the dead window masks the early edge and that the block re-arms afterwards.

// File: rtl/serial_chain_rx.sv
module serial_chain_rx #(
  parameter int BIT_CLKS  = 5208,
  parameter int STAGES    = 4,
  parameter int HOLD_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_line,
  output logic [8*STAGES-1:0] chan_out
);
  localparam int W  = 8 * STAGES;
  localparam int CW = $clog2((HOLD_BITS + 2) * BIT_CLKS);
  localparam logic [CW-1:0] T_FIRST = CW'(BIT_CLKS + BIT_CLKS / 2 - 1);
  localparam logic [CW-1:0] T_NEXT  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] T_HOLD  = CW'(HOLD_BITS * BIT_CLKS - 1);

  logic [2:0]    sync;
  logic          busy, hold;
  logic [CW-1:0] tmr;
  logic [2:0]    nsamp;
  logic [7:0]    stg [STAGES];

  wire rx_s = sync[1];
  wire fell = sync[2] & ~sync[1];
  wire tick = busy && (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync  <= '1;
      busy  <= 1'b0;
      hold  <= 1'b0;
      tmr   <= '0;
      nsamp <= '0;
    end else begin
      sync <= {sync[1:0], rx_line};
      if (busy) begin
        if (tick) begin
          if (nsamp == 3'd7) begin
            busy  <= 1'b0;
            hold  <= 1'b1;
            nsamp <= '0;
            tmr   <= T_HOLD;
          end else begin
            nsamp <= nsamp + 3'd1;
            tmr   <= T_NEXT;
          end
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (hold) begin
        if (tmr == '0) hold <= 1'b0;
        else           tmr  <= tmr - 1'b1;
      end else if (fell) begin
        busy <= 1'b1;
        tmr  <= T_FIRST;
      end
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic feed;
    if (g == 0) begin : g_head
      assign feed = rx_s;
    end else begin : g_tail
      assign feed = stg[g-1][0];
    end
    always_ff @(posedge clk) begin
      if (rst)       stg[g] <= '0;
      else if (tick) stg[g] <= {feed, stg[g][7:1]};
    end
    assign chan_out[8*g +: 8] = ~stg[g];
  end
endmodule

// File: rtl/serial_chain_rx_chk.sv
module serial_chain_rx_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] chan_out,
  input logic         busy,
  input logic         hold,
  input logic [2:0]   nsamp
);
  a_r1_reset_high: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chan_out == {W{1'b1}}));

  a_r4_shift_order: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_out) |-> (chan_out[6:0] == $past(chan_out[7:1])));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(chan_out));

  a_r6_count_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (nsamp == 3'd0));

  a_r7_no_start_in_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(hold));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && hold));
endmodule

bind serial_chain_rx serial_chain_rx_chk #(.W(8*STAGES)) u_chk (
  .clk(clk), .rst(rst), .chan_out(chan_out),
  .busy(busy), .hold(hold), .nsamp(nsamp)
);

// File: tb/sim_serial_chain_rx.sv
module sim_serial_chain_rx;
  localparam int P = 16;
  localparam int S = 4;
  localparam int W = 8 * S;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic [W-1:0] chan_out;
  logic [7:0] mdl [S];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_chain_rx #(.BIT_CLKS(P), .STAGES(S), .HOLD_BITS(2)) u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .chan_out(chan_out)
  );

  function automatic logic [W-1:0] expected();
    logic [W-1:0] v;
    for (int k = 0; k < S; k++) v[8*k +: 8] = ~mdl[k];
    return v;
  endfunction

  task automatic mshift(input logic b);
    for (int k = S - 1; k > 0; k--) mdl[k] = {mdl[k-1][0], mdl[k][7:1]};
    mdl[0] = {b, mdl[0][7:1]};
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (chan_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, chan_out, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (P) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int stops, input bit apply);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    for (int i = 0; i < stops; i++) drive_bit(1'b1);
    if (apply) for (int i = 0; i < 8; i++) mshift(d[i]);
  endtask

  task automatic t_reset();
    for (int k = 0; k < S; k++) mdl[k] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset all high", expected());
  endtask

  task automatic t_order();
    send(8'h41, 2, 1'b1);
    check("R2 lsb-first 0x41", expected());
    checks++;
    if (chan_out[7:0] !== 8'hBE) begin
      errors++;
      $display("FAIL R3 inverted 0x41 actual=%h expected=be", chan_out[7:0]);
    end
  endtask

  task automatic t_extremes();
    send(8'hFF, 2, 1'b1);
    checks++;
    if (chan_out[7:0] !== 8'h00) begin
      errors++;
      $display("FAIL R3 0xFF low actual=%h expected=00", chan_out[7:0]);
    end
    check("R4 carry into stage1", expected());
    send(8'h00, 2, 1'b1);
    checks++;
    if (chan_out[7:0] !== 8'hFF) begin
      errors++;
      $display("FAIL R3 0x00 high actual=%h expected=ff", chan_out[7:0]);
    end
  endtask

  task automatic t_overflow();
    send(8'hA5, 2, 1'b1);
    check("R4 four stages", expected());
    send(8'h3C, 2, 1'b1);
    check("R4 oldest discarded", expected());
  endtask

  task automatic t_midframe();
    logic [7:0] d = 8'h5A;
    drive_bit(1'b0);
    for (int i = 0; i < 4; i++) drive_bit(d[i]);
    for (int i = 0; i < 4; i++) mshift(d[i]);
    check("R5 four bits shifted mid-frame", expected());
    for (int i = 4; i < 8; i++) drive_bit(d[i]);
    for (int i = 4; i < 8; i++) mshift(d[i]);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R6 frame completes", expected());
    repeat (5 * P) @(negedge clk);
    check("R6 idle holds", expected());
  endtask

  task automatic t_deadtime();
    send(8'hC3, 1, 1'b1);
    send(8'hFF, 2, 1'b0);
    check("R7 early start ignored", expected());
    send(8'h96, 2, 1'b1);
    check("R6 re-armed after hold", expected());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_extremes();
    t_overflow();
    t_midframe();
    t_deadtime();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule